// File: doc/BRIEF.md
# Voice Message Record and Playback Sequencer

This block sequences a single-message voice recorder. A free-running frame counter paces the sampling: one sample per frame of `FRAME_CYCLES` clocks (1024 at 8 MHz, about 7.8 kHz), which is also the PWM frame. The first `ADC_DIV * ADC_CLKS` cycles of a frame form the converter window (64 × 14 = 896 at the defaults). The remaining cycles are padding before the next conversion. Three debounced push-button inputs ask for record, erase or playback. Each request is taken on its rising edge and only while the block is idle.

In record mode the block starts a conversion at the top of every frame and supplies the converter with its divided clock strobes. When the window closes, it hands the converted sample to an external encoder. It then packs the returned 4-bit codes two to a memory byte and writes the bytes to ascending addresses. In playback mode it reads the bytes back in the same order and unpacks one code per frame for an external decoder. The decoded sample is loaded into an 8-bit PWM compare value that acts as the DAC. Record and playback each stop on their own after a fixed number of frames, and playback stops earlier when the stored message runs out. Erase only forgets the message length. The converter, the codec and the memory sit outside the block.

Top module: `voice_mode_ctrl`

## Requirements
- R1: After reset `mode` is idle (0), `msg_len` is 0, `pwm_cmp` is 0x80, and `adc_start`, `adc_tick`, `enc_valid`, `dec_valid`, `mem_we` and `mem_re` are low.
- R2: `mode` encodes idle=0, record=1, playback=2, erase=3. A rising edge on a button input while idle selects that mode from the next cycle. When edges coincide, record wins over playback and playback wins over erase.
- R3: Entering record or playback restarts the frame. In record, `adc_start` is high in the first cycle of the mode and then once every `FRAME_CYCLES` cycles.
- R4: In record, `adc_tick` is high in the `adc_start` cycle and then every `ADC_DIV` cycles, `ADC_CLKS` times per frame. It stays low in the padding cycles.
- R5: `enc_valid` rises exactly `ADC_DIV*ADC_CLKS` cycles after `adc_start`. In that cycle `enc_sample` equals `adc_data` and `enc_code` is taken.
- R6: Code 2j of a recording goes to bits [3:0] and code 2j+1 to bits [7:4] of byte j. The byte is written (`mem_we`, `mem_addr`=j) one cycle after the `enc_valid` of code 2j+1. An unpaired last code is written with upper nibble 0 in the first idle cycle after recording.
- R7: Record lasts `REC_FRAMES` frames, or ends earlier at the end of the frame that fills the memory. It then returns to idle, and `msg_len` holds the number of codes stored.
- R8: In playback, for code k, `mem_re` is high in the frame's first cycle with address k/2, but only when k is even. `dec_valid` is high one cycle later, with `dec_code` taken from the low nibble for even k and the high nibble for odd k. `pwm_cmp` loads `dec_sample` on that cycle's closing edge and holds it at all other times.
- R9: Playback returns to idle at the end of the frame in which the code index reaches `msg_len` or `PLAY_FRAMES` frames have elapsed, whichever comes first. With `msg_len` 0 it lasts one frame and produces no read and no decode.
- R10: Erase occupies exactly one cycle, clears `msg_len` (seen as 0 from the next cycle) and causes no memory read or write.
- R11: Button edges that arrive while record or playback is active are dropped and not acted on after the mode ends. An active mode only ever moves to idle.
- R12: `mem_we` and `mem_re` are never high together. `enc_valid`, `adc_start` and `adc_tick` occur only in record, and `dec_valid` only in playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_record | input | 1 | Debounced record button level |
| btn_erase | input | 1 | Debounced erase button level |
| btn_play | input | 1 | Debounced playback button level |
| mode | output | 2 | Current mode (0 idle, 1 record, 2 playback, 3 erase) |
| adc_start | output | 1 | Starts one conversion |
| adc_tick | output | 1 | Converter clock strobe, one per ADC_DIV cycles in the window |
| adc_data | input | 8 | Conversion result, valid at window end |
| enc_valid | output | 1 | Sample presented to encoder |
| enc_sample | output | 8 | Sample for the encoder |
| enc_code | input | 4 | Encoder result for enc_sample |
| dec_valid | output | 1 | Code presented to decoder |
| dec_code | output | 4 | Code for the decoder |
| dec_sample | input | 8 | Decoder result for dec_code |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data due next cycle |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Packed code pair |
| mem_rdata | input | 8 | Read data, one cycle after mem_re |
| pwm_cmp | output | 8 | PWM compare value |
| msg_len | output | ADDR_W+2 | Stored message length in codes |

## Verification
Every result is due at a fixed cycle offset. Counting from the first active cycle of a mode (t=0), frame f occupies t=16f..16f+15 in the bench setup. In that setup `adc_start` is due at offset 0, `enc_valid` at offset 12, the paired write at 13, `mem_re` at 0, `dec_valid` at 1 and the new `pwm_cmp` at 2. The return to idle falls at t = frames × 16, and erase's cleared length appears at t=1. The bench drives buttons and samples every output on the falling edge. It compares each cycle of a whole session against this arithmetic schedule, so an event that comes early, late or twice fails at the cycle where it differs. Two instances with different playback limits share one stimulus, which covers both ways a playback can end.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_REC   = 2'd1,
    MODE_PLAY  = 2'd2,
    MODE_ERASE = 2'd3
  } vmc_mode_e;

  localparam int CODE_W = 4;
  localparam int SMP_W  = 8;
  localparam int BYTE_W = 2 * CODE_W;
  localparam logic [SMP_W-1:0] PWM_MID = 8'h80;

  // first code of a pair sits in the low nibble
  function automatic logic [BYTE_W-1:0] pack_pair(input logic [CODE_W-1:0] first,
                                                  input logic [CODE_W-1:0] second);
    return {second, first};
  endfunction

  function automatic logic [CODE_W-1:0] unpack_code(input logic [BYTE_W-1:0] b,
                                                    input logic upper);
    return upper ? b[BYTE_W-1:CODE_W] : b[CODE_W-1:0];
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vmc_frame_timer.sv
module vmc_frame_timer #(
  parameter int FRAME_CYCLES = 1024,
  parameter int ADC_DIV      = 64,
  parameter int ADC_CLKS     = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic frame_start,
  output logic dec_slot,
  output logic conv_done,
  output logic frame_end,
  output logic div_tick
);
  localparam int CONV = ADC_DIV * ADC_CLKS;
  localparam int FW   = $clog2(FRAME_CYCLES);

  logic [FW-1:0] fpos;
  logic          in_conv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   fpos <= '0;
    else if (restart || frame_end) fpos <= '0;
    else                          fpos <= fpos + FW'(1);
  end

  assign frame_start = (fpos == '0);
  assign dec_slot    = (fpos == FW'(1));
  assign conv_done   = (fpos == FW'(CONV));
  assign frame_end   = (fpos == FW'(FRAME_CYCLES - 1));
  assign in_conv     = (fpos < FW'(CONV));

  generate
    if (ADC_DIV == 1) begin : g_nodiv
      assign div_tick = in_conv;
    end else begin : g_div
      localparam int DW = $clog2(ADC_DIV);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         dcnt <= '0;
        else if (restart || frame_end)      dcnt <= '0;
        else if (dcnt == DW'(ADC_DIV - 1))  dcnt <= '0;
        else                                dcnt <= dcnt + DW'(1);
      end
      assign div_tick = in_conv && (dcnt == '0);
    end
  endgenerate

endmodule

// File: rtl/vmc_mode_fsm.sv
module vmc_mode_fsm
  import vmc_pkg::*;
#(
  parameter int REC_FRAMES  = 65536,
  parameter int PLAY_FRAMES = 65536,
  parameter int LEN_W       = 17,
  parameter int CAP         = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_record,
  input  logic             btn_erase,
  input  logic             btn_play,
  input  logic             frame_end,
  input  logic [LEN_W-1:0] code_idx,
  input  logic [LEN_W-1:0] msg_len,
  output vmc_mode_e        mode,
  output logic             start_rec,
  output logic             start_play,
  output logic             rec_done,
  output logic             play_done
);
  localparam int MAXF = max_of(REC_FRAMES, PLAY_FRAMES);
  localparam int MFW  = $clog2(MAXF + 1);

  logic [2:0]     btn_q;
  logic [2:0]     rise;
  logic           idle;
  logic           start_erase;
  logic [MFW-1:0] mfr;
  vmc_mode_e      mode_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) btn_q <= '0;
    else        btn_q <= {btn_play, btn_erase, btn_record};
  end

  assign rise        = {btn_play, btn_erase, btn_record} & ~btn_q;
  assign idle        = (mode == MODE_IDLE);
  assign start_rec   = idle && rise[0];
  assign start_play  = idle && rise[2] && !rise[0];
  assign start_erase = idle && rise[1] && !rise[0] && !rise[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mfr <= '0;
    else if (start_rec || start_play) mfr <= '0;
    else if (frame_end)               mfr <= mfr + MFW'(1);
  end

  assign rec_done  = (mode == MODE_REC) && frame_end &&
                     ((mfr == MFW'(REC_FRAMES - 1)) || (code_idx == LEN_W'(CAP)));
  assign play_done = (mode == MODE_PLAY) && frame_end &&
                     ((mfr == MFW'(PLAY_FRAMES - 1)) || (code_idx >= msg_len));

  always_comb begin
    mode_nxt = mode;
    unique case (mode)
      MODE_IDLE: begin
        if (start_rec)        mode_nxt = MODE_REC;
        else if (start_play)  mode_nxt = MODE_PLAY;
        else if (start_erase) mode_nxt = MODE_ERASE;
      end
      MODE_REC:   if (rec_done)  mode_nxt = MODE_IDLE;
      MODE_PLAY:  if (play_done) mode_nxt = MODE_IDLE;
      MODE_ERASE: mode_nxt = MODE_IDLE;
      default:    mode_nxt = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_IDLE;
    else        mode <= mode_nxt;
  end

endmodule

// File: rtl/vmc_code_path.sv
module vmc_code_path
  import vmc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LEN_W  = 17,
  parameter int CAP    = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vmc_mode_e         mode,
  input  logic              start_rec,
  input  logic              start_play,
  input  logic              rec_done,
  input  logic              frame_start,
  input  logic              dec_slot,
  input  logic              conv_done,
  input  logic [SMP_W-1:0]  adc_data,
  input  logic [CODE_W-1:0] enc_code,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic [SMP_W-1:0]  dec_sample,
  output logic              enc_valid,
  output logic [SMP_W-1:0]  enc_sample,
  output logic              dec_valid,
  output logic [CODE_W-1:0] dec_code,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [SMP_W-1:0]  pwm_cmp,
  output logic [LEN_W-1:0]  code_idx,
  output logic [LEN_W-1:0]  msg_len
);
  logic              in_rec, in_play, room, more, odd;
  logic [CODE_W-1:0] lo_hold;
  logic [BYTE_W-1:0] byte_hold;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] pair_addr;

  assign in_rec    = (mode == MODE_REC);
  assign in_play   = (mode == MODE_PLAY);
  assign room      = (code_idx < LEN_W'(CAP));
  assign more      = (code_idx < msg_len);
  assign odd       = code_idx[0];
  assign pair_addr = code_idx[ADDR_W:1];

  assign enc_valid  = in_rec && conv_done && room;
  assign enc_sample = adc_data;
  assign mem_re     = in_play && frame_start && more && !odd;
  assign dec_valid  = in_play && dec_slot && more;
  assign dec_code   = unpack_code(odd ? byte_hold : mem_rdata, odd);
  assign mem_addr   = in_play ? pair_addr : wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_idx  <= '0;
      msg_len   <= '0;
      lo_hold   <= '0;
      byte_hold <= '0;
      mem_we    <= 1'b0;
      wr_addr   <= '0;
      mem_wdata <= '0;
      pwm_cmp   <= PWM_MID;
    end else begin
      mem_we <= 1'b0;
      if (start_rec) begin
        code_idx <= '0;
        msg_len  <= '0;
      end else if (start_play) begin
        code_idx <= '0;
      end else if (mode == MODE_ERASE) begin
        msg_len <= '0;
      end else if (enc_valid) begin
        if (!odd) begin
          lo_hold <= enc_code;
        end else begin
          mem_we    <= 1'b1;
          wr_addr   <= pair_addr;
          mem_wdata <= pack_pair(lo_hold, enc_code);
        end
        code_idx <= code_idx + LEN_W'(1);
      end else if (dec_valid) begin
        if (!odd) byte_hold <= mem_rdata;
        pwm_cmp  <= dec_sample;
        code_idx <= code_idx + LEN_W'(1);
      end else if (rec_done) begin
        msg_len <= code_idx;
        if (odd) begin
          mem_we    <= 1'b1;
          wr_addr   <= pair_addr;
          mem_wdata <= pack_pair(lo_hold, '0);
        end
      end
    end
  end

endmodule

// File: rtl/voice_mode_ctrl.sv
module voice_mode_ctrl
  import vmc_pkg::*;
#(
  parameter int FRAME_CYCLES = 1024,
  parameter int ADC_DIV      = 64,
  parameter int ADC_CLKS     = 14,
  parameter int ADDR_W       = 15,
  parameter int REC_FRAMES   = 65536,
  parameter int PLAY_FRAMES  = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_record,
  input  logic              btn_erase,
  input  logic              btn_play,
  output logic [1:0]        mode,
  output logic              adc_start,
  output logic              adc_tick,
  input  logic [7:0]        adc_data,
  output logic              enc_valid,
  output logic [7:0]        enc_sample,
  input  logic [3:0]        enc_code,
  output logic              dec_valid,
  output logic [3:0]        dec_code,
  input  logic [7:0]        dec_sample,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        pwm_cmp,
  output logic [ADDR_W+1:0] msg_len
);
  localparam int LEN_W = ADDR_W + 2;
  localparam int CAP   = 2 ** (ADDR_W + 1);

  vmc_mode_e        mode_q;
  logic             t_frame_start, t_dec_slot, t_conv_done, t_frame_end, t_div_tick;
  logic             start_rec, start_play, rec_done, play_done;
  logic [LEN_W-1:0] code_idx;

  vmc_frame_timer #(
    .FRAME_CYCLES(FRAME_CYCLES), .ADC_DIV(ADC_DIV), .ADC_CLKS(ADC_CLKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(start_rec || start_play),
    .frame_start(t_frame_start), .dec_slot(t_dec_slot), .conv_done(t_conv_done),
    .frame_end(t_frame_end), .div_tick(t_div_tick)
  );

  vmc_mode_fsm #(
    .REC_FRAMES(REC_FRAMES), .PLAY_FRAMES(PLAY_FRAMES), .LEN_W(LEN_W), .CAP(CAP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .btn_record(btn_record), .btn_erase(btn_erase),
    .btn_play(btn_play), .frame_end(t_frame_end), .code_idx(code_idx), .msg_len(msg_len),
    .mode(mode_q), .start_rec(start_rec), .start_play(start_play),
    .rec_done(rec_done), .play_done(play_done)
  );

  vmc_code_path #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CAP(CAP)) u_path (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .start_rec(start_rec),
    .start_play(start_play), .rec_done(rec_done), .frame_start(t_frame_start),
    .dec_slot(t_dec_slot), .conv_done(t_conv_done), .adc_data(adc_data),
    .enc_code(enc_code), .mem_rdata(mem_rdata), .dec_sample(dec_sample),
    .enc_valid(enc_valid), .enc_sample(enc_sample), .dec_valid(dec_valid),
    .dec_code(dec_code), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pwm_cmp(pwm_cmp), .code_idx(code_idx), .msg_len(msg_len)
  );

  assign mode      = mode_q;
  assign adc_start = (mode_q == MODE_REC) && t_frame_start;
  assign adc_tick  = (mode_q == MODE_REC) && t_div_tick;

endmodule

// File: rtl/vmc_checker.sv
module vmc_checker
  import vmc_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             adc_start,
  input logic             adc_tick,
  input logic             enc_valid,
  input logic             dec_valid,
  input logic             mem_we,
  input logic             mem_re,
  input logic [7:0]       pwm_cmp,
  input logic [LEN_W-1:0] msg_len,
  input logic             frame_start
);
  p_start_in_rec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (mode == MODE_REC) && frame_start);

  p_tick_in_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick |-> (mode == MODE_REC));

  p_enc_in_rec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> (mode == MODE_REC));

  p_dec_in_play_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (mode == MODE_PLAY));

  p_pwm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> $stable(pwm_cmp));

  p_erase_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ERASE) |=> (mode == MODE_IDLE) && (msg_len == '0));

  p_erase_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ERASE) |-> !mem_re && !mem_we);

  p_no_switch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_REC) || (mode == MODE_PLAY)) |=>
      ((mode == $past(mode)) || (mode == MODE_IDLE)));

  p_mem_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

bind voice_mode_ctrl vmc_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .adc_start(adc_start), .adc_tick(adc_tick),
  .enc_valid(enc_valid), .dec_valid(dec_valid), .mem_we(mem_we), .mem_re(mem_re),
  .pwm_cmp(pwm_cmp), .msg_len(msg_len), .frame_start(t_frame_start)
);

// File: tb/voice_mode_ctrl_tb.sv
module voice_mode_ctrl_tb;
  localparam int F    = 16;
  localparam int DIV  = 2;
  localparam int CLKS = 6;
  localparam int CONV = DIV * CLKS;
  localparam int AW   = 3;
  localparam int RECF = 11;
  localparam int PLA  = 14;
  localparam int PLB  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_record = 1'b0, btn_erase = 1'b0, btn_play = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // shared stimulus models
  logic [7:0] adc_val;
  int nk;

  logic [1:0] mode_a, mode_b;
  logic adc_start_a, adc_start_b, adc_tick_a, adc_tick_b;
  logic enc_valid_a, enc_valid_b, dec_valid_a, dec_valid_b;
  logic [7:0] enc_sample_a, enc_sample_b;
  logic [3:0] dec_code_a, dec_code_b;
  logic mem_we_a, mem_we_b, mem_re_a, mem_re_b;
  logic [AW-1:0] addr_a, addr_b;
  logic [7:0] wdata_a, wdata_b, rdata_a, rdata_b, pwm_a, pwm_b;
  logic [AW+1:0] len_a, len_b;
  logic [7:0] mem_a [8];
  logic [7:0] mem_b [8];

  function automatic logic [7:0] smp(input int k);
    return 8'(k * 29 + 7);
  endfunction
  function automatic logic [3:0] enc_f(input logic [7:0] s);
    return s[7:4] ^ s[3:0];
  endfunction
  function automatic logic [3:0] code(input int k);
    return enc_f(smp(k));
  endfunction
  function automatic logic [7:0] dec_f(input logic [3:0] c);
    return {c, c ^ 4'hA};
  endfunction

  voice_mode_ctrl #(.FRAME_CYCLES(F), .ADC_DIV(DIV), .ADC_CLKS(CLKS), .ADDR_W(AW),
                    .REC_FRAMES(RECF), .PLAY_FRAMES(PLA)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_record(btn_record), .btn_erase(btn_erase),
    .btn_play(btn_play), .mode(mode_a), .adc_start(adc_start_a), .adc_tick(adc_tick_a),
    .adc_data(adc_val), .enc_valid(enc_valid_a), .enc_sample(enc_sample_a),
    .enc_code(enc_f(enc_sample_a)), .dec_valid(dec_valid_a), .dec_code(dec_code_a),
    .dec_sample(dec_f(dec_code_a)), .mem_we(mem_we_a), .mem_re(mem_re_a),
    .mem_addr(addr_a), .mem_wdata(wdata_a), .mem_rdata(rdata_a), .pwm_cmp(pwm_a),
    .msg_len(len_a));

  voice_mode_ctrl #(.FRAME_CYCLES(F), .ADC_DIV(DIV), .ADC_CLKS(CLKS), .ADDR_W(AW),
                    .REC_FRAMES(RECF), .PLAY_FRAMES(PLB)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .btn_record(btn_record), .btn_erase(btn_erase),
    .btn_play(btn_play), .mode(mode_b), .adc_start(adc_start_b), .adc_tick(adc_tick_b),
    .adc_data(adc_val), .enc_valid(enc_valid_b), .enc_sample(enc_sample_b),
    .enc_code(enc_f(enc_sample_b)), .dec_valid(dec_valid_b), .dec_code(dec_code_b),
    .dec_sample(dec_f(dec_code_b)), .mem_we(mem_we_b), .mem_re(mem_re_b),
    .mem_addr(addr_b), .mem_wdata(wdata_b), .mem_rdata(rdata_b), .pwm_cmp(pwm_b),
    .msg_len(len_b));

  always @(posedge clk) begin
    if (!rst_n) begin
      nk <= 0;
      adc_val <= 8'h00;
    end else if (adc_start_a) begin
      adc_val <= smp(nk);
      nk <= nk + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        mem_a[i] <= 8'hFF;
        mem_b[i] <= 8'hFF;
      end
      rdata_a <= 8'h00;
      rdata_b <= 8'h00;
    end else begin
      if (mem_we_a) mem_a[addr_a] <= wdata_a;
      if (mem_re_a) rdata_a <= mem_a[addr_a];
      if (mem_we_b) mem_b[addr_b] <= wdata_b;
      if (mem_re_b) rdata_b <= mem_b[addr_b];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic press(input bit r, input bit e, input bit p);
    @(negedge clk);
    btn_record = r;
    btn_erase  = e;
    btn_play   = p;
  endtask

  task automatic release_all();
    btn_record = 1'b0;
    btn_erase  = 1'b0;
    btn_play   = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int nk0;
    int t0len;
    logic [7:0] snap [8];
    logic [7:0] pwm_keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", int'(mode_a), 0);
    chk("R1 msg_len", int'(len_a), 0);
    chk("R1 pwm_cmp", int'(pwm_a), 8'h80);
    chk("R1 strobes", int'({adc_start_a, adc_tick_a, enc_valid_a, dec_valid_a,
                            mem_we_a, mem_re_a}), 0);

    // record session, R3 R4 R5 R6 R7, play press mid-record for R11
    nk0 = nk;
    press(1'b1, 1'b0, 1'b0);
    for (int t = 0; t < 180; t++) begin
      int k;
      int p;
      bit act;
      bit wexp;
      @(negedge clk);
      k = t / F;
      p = t % F;
      act = (t < RECF * F);
      chk("R7 record mode", int'(mode_a), act ? 1 : 0);
      chk("R3 adc_start", int'(adc_start_a), int'(act && p == 0));
      chk("R4 adc_tick", int'(adc_tick_a), int'(act && p < CONV && (p % DIV) == 0));
      chk("R5 enc_valid", int'(enc_valid_a), int'(act && p == CONV));
      if (act && p == CONV) chk("R5 enc_sample", int'(enc_sample_a), int'(smp(nk0 + k)));
      wexp = (act && p == CONV + 1 && (k % 2) == 1) || (t == RECF * F);
      chk("R6 mem_we", int'(mem_we_a), int'(wexp));
      chk("R12 no read in record", int'(mem_re_a), 0);
      if (wexp && t == RECF * F) begin
        chk("R6 flush addr", int'(addr_a), RECF / 2);
        chk("R6 flush data", int'(wdata_a), int'({4'h0, code(nk0 + RECF - 1)}));
      end else if (wexp) begin
        chk("R6 write addr", int'(addr_a), k / 2);
        chk("R6 write data", int'(wdata_a), int'({code(nk0 + k), code(nk0 + k - 1)}));
      end
      if (t == 2) release_all();
      if (t == 40) btn_play = 1'b1;
      if (t == 43) btn_play = 1'b0;
    end
    repeat (6) begin
      @(negedge clk);
      chk("R11 dropped press", int'(mode_a), 0);
    end
    chk("R7 msg_len", int'(len_a), RECF);
    chk("R7 msg_len short", int'(len_b), RECF);
    for (int j = 0; j < 6; j++) begin
      logic [7:0] eb;
      eb = (j < 5) ? {code(nk0 + 2 * j + 1), code(nk0 + 2 * j)} : {4'h0, code(nk0 + 10)};
      chk("R6 memory byte", int'(mem_a[j]), int'(eb));
      chk("R6 memory byte s", int'(mem_b[j]), int'(eb));
    end

    // playback: u_dut ends on length (R9), u_dut_s ends on frame limit (R9)
    press(1'b0, 1'b0, 1'b1);
    for (int t = 0; t < 180; t++) begin
      int k;
      int p;
      bit aa;
      bit ab;
      @(negedge clk);
      k = t / F;
      p = t % F;
      aa = (t < RECF * F);
      ab = (t < PLB * F);
      chk("R9 play mode", int'(mode_a), aa ? 2 : 0);
      chk("R9 play mode limit", int'(mode_b), ab ? 2 : 0);
      chk("R8 mem_re", int'(mem_re_a), int'(aa && p == 0 && (k % 2) == 0));
      if (aa && p == 0 && (k % 2) == 0) chk("R8 read addr", int'(addr_a), k / 2);
      chk("R8 dec_valid", int'(dec_valid_a), int'(aa && p == 1));
      chk("R9 dec_valid limit", int'(dec_valid_b), int'(ab && p == 1));
      if (aa && p == 1) chk("R8 dec_code", int'(dec_code_a), int'(code(nk0 + k)));
      if (aa && p == 2) chk("R8 pwm_cmp", int'(pwm_a), int'(dec_f(code(nk0 + k))));
      if (!ab) chk("R9 pwm held", int'(pwm_b), int'(dec_f(code(nk0 + PLB - 1))));
      chk("R12 no write in play", int'(mem_we_a), 0);
      if (t == 2) release_all();
    end

    // erase R10
    for (int j = 0; j < 8; j++) snap[j] = mem_a[j];
    pwm_keep = pwm_a;
    press(1'b0, 1'b1, 1'b0);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      chk("R10 erase mode", int'(mode_a), (t == 0) ? 3 : 0);
      if (t > 0) chk("R10 msg_len cleared", int'(len_a), 0);
      chk("R10 no memory traffic", int'({mem_we_a, mem_re_a}), 0);
      if (t == 2) release_all();
    end
    for (int j = 0; j < 8; j++) chk("R10 memory kept", int'(mem_a[j]), int'(snap[j]));

    // empty playback R9
    press(1'b0, 1'b0, 1'b1);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      chk("R9 empty play mode", int'(mode_a), (t < F) ? 2 : 0);
      chk("R9 empty no decode", int'({dec_valid_a, mem_re_a}), 0);
      chk("R9 empty pwm", int'(pwm_a), int'(pwm_keep));
      if (t == 2) release_all();
    end

    // priority R2
    press(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R2 record wins", int'(mode_a), 1);
    release_all();
    repeat (RECF * F + 4) @(negedge clk);
    t0len = int'(len_a);
    chk("R2 re-record length", t0len, RECF);
    press(1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R2 playback beats erase", int'(mode_a), 2);
    release_all();
    repeat (RECF * F + 4) @(negedge clk);
    chk("R2 idle after play", int'(mode_a), 0);
    chk("R2 length kept", int'(len_a), RECF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule